// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after instruction fetch. Each cycle it can take a window of up to six bytes read at the current program counter. From the first byte it works out how long the instruction is. It then pulls out the operation type, the function code, two register identifiers and a 32-bit constant, and it computes the address of the next sequential instruction. All results come out of one register stage, one cycle after the window is presented with its valid strobe.

The first byte holds the operation type in its upper nibble and the function code in its lower nibble. That byte alone fixes the length: 1, 2, 5 or 6 bytes. A register byte, when one is present, is always the second byte. Constants are absolute 32-bit values stored least-significant byte first. They follow the register byte in 6-byte forms and follow the first byte directly in 5-byte forms. The register identifier 8 means "no register".

An opcode byte outside the defined set raises an illegal flag. So does a function code that its type does not allow. In either case the decoded length is forced to one byte, so the fetch stage can step past the byte.

Top module: `fetch_decoder`

## Requirements
- R1: While reset (`rstN` low) is applied, and until the first decode, every output is zero: `outValid`, `illegal`, `icode`, `ifun`, `regA`, `regB`, `constVal`, `instLen` and `nextPc`.
- R2: `outValid` is high in the cycle after a rising clock edge that samples `inValid` high, and low in the cycle after an edge that samples it low. When `inValid` is low, every other output keeps its last decoded value.
- R3: The length depends on the upper nibble of byte 0 (bits 7:0 of `fetchBytes`). Types 0x0 (no-op), 0x1 (halt) and 0x9 (return) give 1. Types 0x2 (register move), 0x6 (ALU), 0xA (push) and 0xB (pop) give 2. Types 0x7 (jump) and 0x8 (call) give 5. Types 0x3 (immediate move), 0x4 (store) and 0x5 (load) give 6.
- R4: `icode` equals bits 7:4 and `ifun` equals bits 3:0 of byte 0 for every decoded window, legal or illegal.
- R5: For 2-byte and 6-byte instructions, `regA` is bits 15:12 and `regB` is bits 11:8 of `fetchBytes`. For 1-byte, 5-byte and illegal instructions, both are 8 (no register).
- R6: For 6-byte instructions, `constVal` is bytes 2..5 read little-endian, with byte 2 as the least significant. For 5-byte instructions it is bytes 1..4 read the same way. For every other case it is zero.
- R7: `nextPc` equals the sampled `pc` plus `instLen`, modulo 2^32.
- R8: An instruction is illegal, with `illegal` high, `instLen` 1, both registers 8 and the constant 0, in any of these cases: the type is 0xC..0xF; an ALU function code is above 3; a jump function code is above 6; or any other type has a nonzero function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Fetch window and PC are valid this cycle |
| pc | input | 32 | Address of byte 0 of the window |
| fetchBytes | input | 48 | Fetch window; byte k sits in bits 8k+7:8k |
| outValid | output | 1 | Decoded fields are fresh |
| illegal | output | 1 | Opcode byte is not a defined instruction |
| icode | output | 4 | Operation type nibble |
| ifun | output | 4 | Function code nibble |
| regA | output | 4 | First register ID, 8 when unused |
| regB | output | 4 | Second register ID, 8 when unused |
| constVal | output | 32 | Immediate, displacement or absolute target |
| instLen | output | 4 | Instruction length in bytes |
| nextPc | output | 32 | Address of the following instruction |

## Verification
Two behaviours can apply to the same window: the illegal-opcode override, which shrinks the length to one byte, and the 32-bit wrap of the next-PC adder. The bench places an illegal byte at address 0xFFFFFFFF, where the next PC must be 0. It also places legal 5-byte and 6-byte forms just below the top of the address space, where the sum must wrap to a small value. It judges each case by the length, the empty register fields and the wrapped sum seen at the ports. The hold test changes the input bytes while `inValid` is low and checks that none of the decoded fields move.

// File: rtl/fetch_dec_pkg.sv
package fetch_dec_pkg;

  localparam int NIB_W = 4;
  localparam int LEN_W = 4;

  localparam logic [NIB_W-1:0] REG_NONE = 4'h8;

  localparam logic [NIB_W-1:0] OP_NOP   = 4'h0;
  localparam logic [NIB_W-1:0] OP_HALT  = 4'h1;
  localparam logic [NIB_W-1:0] OP_RRMOV = 4'h2;
  localparam logic [NIB_W-1:0] OP_IRMOV = 4'h3;
  localparam logic [NIB_W-1:0] OP_STORE = 4'h4;
  localparam logic [NIB_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [NIB_W-1:0] OP_ALU   = 4'h6;
  localparam logic [NIB_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [NIB_W-1:0] OP_CALL  = 4'h8;
  localparam logic [NIB_W-1:0] OP_RET   = 4'h9;
  localparam logic [NIB_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [NIB_W-1:0] OP_POP   = 4'hB;

  localparam logic [NIB_W-1:0] ALU_FUN_MAX  = 4'h3;
  localparam logic [NIB_W-1:0] JUMP_FUN_MAX = 4'h6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             illegal;
    logic             regByte;      // byte 1 carries rA/rB
    logic             constAfterReg; // constant starts at byte 2
    logic             constNoReg;   // constant starts at byte 1
    logic [LEN_W-1:0] len;
  } decStrobe_t;

endpackage

// File: rtl/fetch_dec_ctrl.sv
module fetch_dec_ctrl
  import fetch_dec_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input  logic [7:0]  opByte,
  output decStrobe_t  strobe
);

  localparam logic [LEN_W-1:0] CONST_LEN = LEN_W'(CONST_BYTES);

  logic [NIB_W-1:0] opType;
  logic [NIB_W-1:0] opFun;
  logic             known;
  logic             funOk;
  logic             regRaw;
  logic             constRegRaw;
  logic             constJmpRaw;
  logic             bad;

  assign opType = opByte[7:4];
  assign opFun  = opByte[3:0];

  always_comb begin
    known       = 1'b1;
    funOk       = (opFun == 4'h0);
    regRaw      = 1'b0;
    constRegRaw = 1'b0;
    constJmpRaw = 1'b0;
    case (opType)
      OP_NOP, OP_HALT, OP_RET: ;
      OP_RRMOV, OP_PUSH, OP_POP: regRaw = 1'b1;
      OP_ALU: begin
        regRaw = 1'b1;
        funOk  = (opFun <= ALU_FUN_MAX);
      end
      OP_IRMOV, OP_STORE, OP_LOAD: begin
        regRaw      = 1'b1;
        constRegRaw = 1'b1;
      end
      OP_JUMP: begin
        constJmpRaw = 1'b1;
        funOk       = (opFun <= JUMP_FUN_MAX);
      end
      OP_CALL: constJmpRaw = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign bad = !(known && funOk);

  always_comb begin
    strobe               = '0;
    strobe.illegal       = bad;
    strobe.regByte       = regRaw && !bad;
    strobe.constAfterReg = constRegRaw && !bad;
    strobe.constNoReg    = constJmpRaw && !bad;
    strobe.len           = LEN_W'(1)
                         + (strobe.regByte ? LEN_W'(1) : '0)
                         + ((strobe.constAfterReg || strobe.constNoReg) ? CONST_LEN : '0);
  end

endmodule

// File: rtl/fetch_dec_datapath.sv
module fetch_dec_datapath
  import fetch_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CONST_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [ADDR_W-1:0]          pc,
  input  logic [8*(CONST_BYTES+2)-1:0] window,
  input  decStrobe_t                 strobe,
  output logic                       outValid,
  output logic                       illegal,
  output logic [NIB_W-1:0]           icode,
  output logic [NIB_W-1:0]           ifun,
  output logic [NIB_W-1:0]           regA,
  output logic [NIB_W-1:0]           regB,
  output logic [8*CONST_BYTES-1:0]   constVal,
  output logic [LEN_W-1:0]           instLen,
  output logic [ADDR_W-1:0]          nextPc
);

  localparam int CONST_W = 8 * CONST_BYTES;

  logic [CONST_W-1:0] constFromTwo;
  logic [CONST_W-1:0] constFromOne;
  logic [CONST_W-1:0] constSel;
  logic [NIB_W-1:0]   regASel;
  logic [NIB_W-1:0]   regBSel;
  logic [ADDR_W-1:0]  pcSum;

  // Little-endian assembly: lowest-addressed byte lands lowest.
  for (genvar k = 0; k < CONST_BYTES; k++) begin : gLeByte
    assign constFromTwo[8*k +: 8] = window[8*(k+2) +: 8];
    assign constFromOne[8*k +: 8] = window[8*(k+1) +: 8];
  end

  always_comb begin
    if (strobe.constAfterReg)   constSel = constFromTwo;
    else if (strobe.constNoReg) constSel = constFromOne;
    else                        constSel = '0;
  end

  assign regASel = strobe.regByte ? window[15:12] : REG_NONE;
  assign regBSel = strobe.regByte ? window[11:8]  : REG_NONE;
  assign pcSum   = pc + ADDR_W'(strobe.len);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
      icode    <= '0;
      ifun     <= '0;
      regA     <= '0;
      regB     <= '0;
      constVal <= '0;
      instLen  <= '0;
      nextPc   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        illegal  <= strobe.illegal;
        icode    <= window[7:4];
        ifun     <= window[3:0];
        regA     <= regASel;
        regB     <= regBSel;
        constVal <= constSel;
        instLen  <= strobe.len;
        nextPc   <= pcSum;
      end
    end
  end

endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
  import fetch_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CONST_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [ADDR_W-1:0]            pc,
  input  logic [8*(CONST_BYTES+2)-1:0] fetchBytes,
  output logic                         outValid,
  output logic                         illegal,
  output logic [3:0]                   icode,
  output logic [3:0]                   ifun,
  output logic [3:0]                   regA,
  output logic [3:0]                   regB,
  output logic [8*CONST_BYTES-1:0]     constVal,
  output logic [3:0]                   instLen,
  output logic [ADDR_W-1:0]            nextPc
);

  decStrobe_t strobe;

  fetch_dec_ctrl #(.CONST_BYTES(CONST_BYTES)) uCtrl (
    .opByte (fetchBytes[7:0]),
    .strobe (strobe)
  );

  fetch_dec_datapath #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .pc       (pc),
    .window   (fetchBytes),
    .strobe   (strobe),
    .outValid (outValid),
    .illegal  (illegal),
    .icode    (icode),
    .ifun     (ifun),
    .regA     (regA),
    .regB     (regB),
    .constVal (constVal),
    .instLen  (instLen),
    .nextPc   (nextPc)
  );

endmodule

// File: rtl/fetch_decoder_chk.sv
module fetch_decoder_chk #(
  parameter int ADDR_W      = 32,
  parameter int CONST_BYTES = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inValid,
  input logic [ADDR_W-1:0]            pc,
  input logic [8*(CONST_BYTES+2)-1:0] fetchBytes,
  input logic                         outValid,
  input logic                         illegal,
  input logic [3:0]                   icode,
  input logic [3:0]                   ifun,
  input logic [3:0]                   regA,
  input logic [3:0]                   regB,
  input logic [8*CONST_BYTES-1:0]     constVal,
  input logic [3:0]                   instLen,
  input logic [ADDR_W-1:0]            nextPc
);

  localparam logic [3:0] LEN_LONG  = 4'(CONST_BYTES + 2);
  localparam logic [3:0] LEN_JUMPY = 4'(CONST_BYTES + 1);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(nextPc) && $stable(constVal) && $stable(icode) && $stable(regA)));

  a_r4_nibbles: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (icode == $past(fetchBytes[7:4]) && ifun == $past(fetchBytes[3:0])));

  a_r3_len_set: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal) |-> (instLen == 4'd1 || instLen == 4'd2
                                || instLen == LEN_JUMPY || instLen == LEN_LONG));

  a_r6_long_const: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && instLen == LEN_LONG) |-> constVal == $past(fetchBytes[8*(CONST_BYTES+2)-1:16]));

  a_r7_next_pc: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> nextPc == $past(pc) + ADDR_W'(instLen));

  a_r8_illegal_short: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (instLen == 4'd1 && regA == 4'h8 && regB == 4'h8 && constVal == '0));

endmodule

bind fetch_decoder fetch_decoder_chk #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) uChk (.*);

// File: tb/tb_fetch_decoder.sv
`timescale 1ns/1ps
module tb_fetch_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] fetchBytes = '0;
  logic        outValid, illegal;
  logic [3:0]  icode, ifun, regA, regB, instLen;
  logic [31:0] constVal, nextPc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fetch_decoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pc(pc), .fetchBytes(fetchBytes),
    .outValid(outValid), .illegal(illegal), .icode(icode), .ifun(ifun),
    .regA(regA), .regB(regB), .constVal(constVal), .instLen(instLen), .nextPc(nextPc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one window, check the decode one edge later.
  task automatic decodeOne(input logic [31:0] atPc, input logic [47:0] win);
    logic [3:0]  ic, fn, eA, eB;
    int          len;
    bit          ill;
    logic [31:0] eC;
    ic = win[7:4];
    fn = win[3:0];
    case (ic)
      4'h0, 4'h1, 4'h9:       begin len = 1; ill = (fn != 0); end
      4'h2, 4'hA, 4'hB:       begin len = 2; ill = (fn != 0); end
      4'h6:                   begin len = 2; ill = (fn > 3);  end
      4'h3, 4'h4, 4'h5:       begin len = 6; ill = (fn != 0); end
      4'h7:                   begin len = 5; ill = (fn > 6);  end
      4'h8:                   begin len = 5; ill = (fn != 0); end
      default:                begin len = 1; ill = 1'b1;      end
    endcase
    if (ill) len = 1;
    eA = (len == 2 || len == 6) ? win[15:12] : 4'h8;
    eB = (len == 2 || len == 6) ? win[11:8]  : 4'h8;
    eC = (len == 6) ? win[47:16] : (len == 5) ? win[39:8] : 32'h0;
    @(negedge clk);
    pc = atPc;
    fetchBytes = win;
    inValid = 1'b1;
    @(negedge clk);
    check("R2", "outValid", 32'(outValid), 32'd1);
    check("R8", "illegal", 32'(illegal), 32'(ill));
    check("R4", "icode", 32'(icode), 32'(ic));
    check("R4", "ifun", 32'(ifun), 32'(fn));
    check("R3", "instLen", 32'(instLen), 32'(len));
    check("R5", "regA", 32'(regA), 32'(eA));
    check("R5", "regB", 32'(regB), 32'(eB));
    check("R6", "constVal", constVal, eC);
    check("R7", "nextPc", nextPc, atPc + 32'(len));
    inValid = 1'b0;
  endtask

  task automatic tReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "outValid in reset", 32'(outValid), 0);
    check("R1", "illegal in reset", 32'(illegal), 0);
    check("R1", "nextPc in reset", nextPc, 0);
    check("R1", "constVal in reset", constVal, 0);
    check("R1", "fields in reset", {16'h0, icode, ifun, regA, regB}, 0);
    check("R1", "instLen in reset", 32'(instLen), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after release", 32'(outValid), 0);
  endtask

  task automatic tMoves();
    decodeOne(32'h0000_0100, 48'h0000_abcd_8230);   // irmov 0xabcd -> r2 (R3 R6)
    decodeOne(32'h0000_0106, 48'h0000_0000_4320);   // reg move
    decodeOne(32'h0000_0108, 48'hffff_fff4_1550);   // load, negative displacement
    decodeOne(32'h0000_010e, 48'h0000_041c_6440);   // store
  endtask

  task automatic tAluJump();
    decodeOne(32'h0000_0200, 48'h5555_5555_0660);   // ALU add, junk after
    decodeOne(32'h0000_0202, 48'h0000_0000_1263);   // ALU fun 3 legal
    decodeOne(32'h0000_0204, 48'h00aa_0000_1234_74 >> 0); // jump fun 4, target 0x1234
    decodeOne(32'h0000_0209, 48'h0099_8765_4321_80); // call, target 0x87654321
    decodeOne(32'h0000_020e, 48'h0000_dead_beef_76); // jump fun 6 legal
  endtask

  task automatic tStack();
    decodeOne(32'h0000_0300, 48'h0000_0000_28a0);   // push
    decodeOne(32'h0000_0302, 48'h0000_0000_38b0);   // pop
    decodeOne(32'h0000_0304, 48'hffff_ffff_ff10);   // halt, trailing bytes ignored
    decodeOne(32'h0000_0305, 48'h1234_5678_9a00);   // no-op
    decodeOne(32'h0000_0306, 48'h1234_5678_9a90);   // return
  endtask

  task automatic tIllegal();
    decodeOne(32'h0000_0400, 48'h1122_3344_5564);   // R8 ALU fun 4
    decodeOne(32'h0000_0401, 48'h1122_3344_5577);   // R8 jump fun 7
    decodeOne(32'h0000_0402, 48'h1122_3344_55c0);   // R8 type C
    decodeOne(32'h0000_0403, 48'h1122_3344_55f5);   // R8 type F
    decodeOne(32'h0000_0404, 48'h1122_3344_5521);   // R8 move with fun 1
    decodeOne(32'h0000_0405, 48'h1122_3344_5532);   // R8 irmov with fun 2
  endtask

  task automatic tWrap();
    decodeOne(32'hffff_ffff, 48'h0000_0000_00d0);   // R7 R8 illegal at top -> 0
    decodeOne(32'hffff_fffc, 48'h0000_0001_f530);   // R7 6-byte wraps to 2
    decodeOne(32'hffff_fffe, 48'h0000_0000_1080);   // R7 5-byte wraps to 3
  endtask

  task automatic tHold();
    logic [31:0] keepC, keepP;
    logic [15:0] keepF;
    decodeOne(32'h0000_0500, 48'h0000_7777_0130);
    keepC = constVal;
    keepP = nextPc;
    keepF = {icode, ifun, regA, regB};
    @(negedge clk);
    fetchBytes = 48'hffff_ffff_ffc5;
    pc = 32'h1234_0000;
    @(negedge clk);
    @(negedge clk);
    check("R2", "outValid idle", 32'(outValid), 0);
    check("R2", "constVal held", constVal, keepC);
    check("R2", "nextPc held", nextPc, keepP);
    check("R2", "fields held", 32'(keepF), 32'({icode, ifun, regA, regB}));
  endtask

  initial begin
    tReset();
    tMoves();
    tAluJump();
    tStack();
    tIllegal();
    tWrap();
    tHold();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule